// File: doc/BRIEF.md
# Stack Pointer Delta Tracker

This unit sits in the decode stage. It folds the implicit stack-pointer moves of push, pop, call and return into a signed running offset. Those operations therefore leave the block as a single micro-op each, with no separate add or subtract of the stack pointer. While the offset is being tracked, consecutive stack operations do not depend on the stack-pointer register. Each one carries the offset that its stack-relative address must use.

When an operation names the stack pointer as an explicit source or destination, the block first inserts one synchronization micro-op. That micro-op carries the accumulated offset, so the real register can be corrected. The offset then returns to zero, and the explicit operation follows unchanged. A sync is also forced when the next update would push the offset outside its signed field. A flush input discards the tracked offset.

The block moves one descriptor per cycle under a valid/ready handshake. The path from input to output is combinational. A small state machine has two states:

- `ST_TRACK`: normal tracking. A sync may be emitted in this state.
- `ST_RESUME`: the held operation passes after its sync.

There are three transitions:

- `T_SYNC_SENT`: from `ST_TRACK` to `ST_RESUME`, when a sync micro-op is accepted.
- `T_OP_SENT`: from `ST_RESUME` to `ST_TRACK`, when the held operation is accepted.
- `T_FLUSH`: from any state to `ST_TRACK`.

Top module: `spt_delta_tracker`

## Requirements
- R1: A push (class code 1) or call (class code 3) that passes without sync is output with offset equal to the tracked offset minus its size, and the tracked offset takes that value.
- R2: A pop (class code 2) or return (class code 4) that passes without sync is output with the tracked offset unchanged, and the tracked offset then rises by its size.
- R3: A stack operation that needs no sync passes as exactly one micro-op (out_sync low), and in_ready equals out_ready in that cycle.
- R4: An operation with in_sp_explicit set, while the tracked offset is nonzero, first yields a sync micro-op with out_sync high, class 0, tag 0 and out_offset equal to the tracked offset, with in_ready low. After that micro-op is accepted, the offset is 0 and the same operation passes with its class and tag unchanged.
- R5: An explicit operation arriving while the offset is already 0 passes at once with no sync.
- R6: A stack operation whose update would leave the signed OFS_W-bit range forces a sync first. It then passes computed from offset 0.
- R7: While flush is high, out_valid and in_ready are low. The tracked offset is 0 in the next cycle.
- R8: While out_ready is low, no operation is consumed, in_ready is low and the tracked offset does not change.
- R9: After reset, the offset is 0, out_valid is low and in_ready follows out_ready.
- R10: A non-stack operation (class 0) without the explicit flag passes with the current offset, and leaves the offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Pipeline flush; clears the offset |
| in_valid | input | 1 | Input descriptor valid |
| in_ready | output | 1 | Input descriptor accepted this cycle |
| in_class | input | 3 | Operation class: 0 other, 1 push, 2 pop, 3 call, 4 return |
| in_size | input | SZ_W | Bytes moved by push/pop |
| in_sp_explicit | input | 1 | Operation reads or writes the stack pointer explicitly |
| in_tag | input | TAG_W | Opaque operation identifier |
| out_valid | output | 1 | Output micro-op valid |
| out_ready | input | 1 | Downstream accepts the micro-op |
| out_sync | output | 1 | Output is an inserted sync micro-op |
| out_class | output | 3 | Class of the output micro-op (0 for sync) |
| out_tag | output | TAG_W | Tag of the output micro-op (0 for sync) |
| out_offset | output | OFS_W | Address offset, or the accumulated offset for a sync |

## Verification
The bench narrows the offset field to 6 bits and the size field to 4 bits. Overflow in both directions is then reached after a handful of pushes or pops. The random run therefore hits forced syncs often, alongside explicit-pointer syncs, flushes and downstream stalls. With sizes up to 15 against a range of -32..31, one operation can never overflow from offset 0. This keeps the post-sync pass of R6 reachable and unambiguous.

// File: rtl/spt_pkg.sv
package spt_pkg;

    typedef enum logic [2:0] {
        OPC_OTHER = 3'd0,
        OPC_PUSH  = 3'd1,
        OPC_POP   = 3'd2,
        OPC_CALL  = 3'd3,
        OPC_RET   = 3'd4
    } opc_e;

    typedef enum logic {
        ST_TRACK  = 1'b0,
        ST_RESUME = 1'b1
    } trk_state_e;

endpackage

// File: rtl/spt_classify.sv
module spt_classify
    import spt_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int SZ_W  = 5
) (
    input  logic [OFS_W-1:0] cur_off,
    input  logic [2:0]       op_class,
    input  logic [SZ_W-1:0]  op_size,
    input  logic             sp_expl,
    input  logic             allow_sync,
    output logic             need_sync,
    output logic [OFS_W-1:0] addr_off,
    output logic [OFS_W-1:0] next_off
);
    localparam int EW = OFS_W + 1;

    logic signed [EW-1:0] cur_x;
    logic signed [EW-1:0] size_x;
    logic signed [EW-1:0] lowered;
    logic signed [EW-1:0] raised;
    logic lo_bad, hi_bad, is_push, is_pop, ovf;

    always_comb begin
        cur_x   = {cur_off[OFS_W-1], cur_off};
        size_x  = EW'(op_size);
        lowered = cur_x - size_x;
        raised  = cur_x + size_x;
        // result fits OFS_W bits only when the two top bits agree
        lo_bad  = lowered[EW-1] != lowered[EW-2];
        hi_bad  = raised[EW-1]  != raised[EW-2];
    end

    always_comb begin
        is_push = 1'b0;
        is_pop  = 1'b0;
        unique case (op_class)
            OPC_PUSH, OPC_CALL: is_push = 1'b1;
            OPC_POP,  OPC_RET:  is_pop  = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        ovf       = (is_push && lo_bad) || (is_pop && hi_bad);
        need_sync = allow_sync && (cur_off != '0) && (sp_expl || ovf);
        addr_off  = is_push ? lowered[OFS_W-1:0] : cur_off;
        if (is_push)     next_off = lowered[OFS_W-1:0];
        else if (is_pop) next_off = raised[OFS_W-1:0];
        else             next_off = cur_off;
    end

endmodule

// File: rtl/spt_fsm.sv
module spt_fsm
    import spt_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             xfer,
    input  logic             xfer_sync,
    input  logic [OFS_W-1:0] next_off,
    output logic [OFS_W-1:0] off_q,
    output logic             allow_sync
);
    trk_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_TRACK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = ST_TRACK;                       // T_FLUSH
        end else begin
            unique case (state_q)
                ST_TRACK:  if (xfer && xfer_sync) state_d = ST_RESUME; // T_SYNC_SENT
                ST_RESUME: if (xfer)              state_d = ST_TRACK;  // T_OP_SENT
                default:                          state_d = ST_TRACK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                off_q <= '0;
        else if (flush)            off_q <= '0;
        else if (xfer && xfer_sync) off_q <= '0;
        else if (xfer)             off_q <= next_off;
    end

    always_comb allow_sync = (state_q == ST_TRACK);

    // R4
    resume_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESUME) |-> (off_q == '0));

    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (off_q == '0) && (state_q == ST_TRACK));

endmodule

// File: rtl/spt_outmux.sv
module spt_outmux #(
    parameter int OFS_W = 8,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_valid,
    input  logic             out_ready,
    input  logic             need_sync,
    input  logic [OFS_W-1:0] cur_off,
    input  logic [OFS_W-1:0] addr_off,
    input  logic [2:0]       in_class,
    input  logic [TAG_W-1:0] in_tag,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_sync,
    output logic [2:0]       out_class,
    output logic [TAG_W-1:0] out_tag,
    output logic [OFS_W-1:0] out_offset
);
    always_comb begin
        out_valid  = in_valid && !flush;
        out_sync   = out_valid && need_sync;
        in_ready   = !flush && out_ready && !out_sync;
        out_class  = out_sync ? 3'd0 : in_class;
        out_tag    = out_sync ? '0 : in_tag;
        out_offset = out_sync ? cur_off : addr_off;
    end

    // R4
    sync_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sync |-> !in_ready);

    // R7
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!out_valid && !in_ready));

endmodule

// File: rtl/spt_delta_tracker.sv
module spt_delta_tracker
    import spt_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int SZ_W  = 5,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [2:0]       in_class,
    input  logic [SZ_W-1:0]  in_size,
    input  logic             in_sp_explicit,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_sync,
    output logic [2:0]       out_class,
    output logic [TAG_W-1:0] out_tag,
    output logic [OFS_W-1:0] out_offset
);
    logic [OFS_W-1:0] off_q, addr_off, next_off;
    logic need_sync, allow_sync, xfer;

    spt_classify #(.OFS_W(OFS_W), .SZ_W(SZ_W)) u_cls (
        .cur_off    (off_q),
        .op_class   (in_class),
        .op_size    (in_size),
        .sp_expl    (in_sp_explicit),
        .allow_sync (allow_sync),
        .need_sync  (need_sync),
        .addr_off   (addr_off),
        .next_off   (next_off)
    );

    spt_outmux #(.OFS_W(OFS_W), .TAG_W(TAG_W)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .in_valid   (in_valid),
        .out_ready  (out_ready),
        .need_sync  (need_sync),
        .cur_off    (off_q),
        .addr_off   (addr_off),
        .in_class   (in_class),
        .in_tag     (in_tag),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_sync   (out_sync),
        .out_class  (out_class),
        .out_tag    (out_tag),
        .out_offset (out_offset)
    );

    always_comb xfer = out_valid && out_ready;

    spt_fsm #(.OFS_W(OFS_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .xfer       (xfer),
        .xfer_sync  (out_sync),
        .next_off   (next_off),
        .off_q      (off_q),
        .allow_sync (allow_sync)
    );

    // R1
    push_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !out_sync && (in_class == 3'd1 || in_class == 3'd3))
        |=> (off_q == OFS_W'($past(off_q) - OFS_W'($past(in_size)))));

    // R2
    pop_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !out_sync && (in_class == 3'd2 || in_class == 3'd4))
        |=> (off_q == OFS_W'($past(off_q) + OFS_W'($past(in_size)))));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_ready && !flush) |=> $stable(off_q));

endmodule

// File: tb/spt_delta_tracker_tb_top.sv
`timescale 1ns/1ps
module spt_delta_tracker_tb_top;
    localparam int OW = 6;
    localparam int SW = 4;
    localparam int TW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0, in_valid = 1'b0, out_ready = 1'b1, in_sp_explicit = 1'b0;
    logic [2:0] in_class = '0;
    logic [SW-1:0] in_size = '0;
    logic [TW-1:0] in_tag = '0;
    logic in_ready, out_valid, out_sync;
    logic [2:0] out_class;
    logic [TW-1:0] out_tag;
    logic [OW-1:0] out_offset;

    int n_checks = 0;
    int n_fail = 0;
    int mdl_off = 0;
    bit last_accept = 0;

    always #10 clk = ~clk;

    spt_delta_tracker #(.OFS_W(OW), .SZ_W(SW), .TAG_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
        .in_class(in_class), .in_size(in_size), .in_sp_explicit(in_sp_explicit),
        .in_tag(in_tag), .out_valid(out_valid), .out_ready(out_ready), .out_sync(out_sync),
        .out_class(out_class), .out_tag(out_tag), .out_offset(out_offset)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit f_push(int c); return c == 1 || c == 3; endfunction
    function automatic bit f_pop(int c);  return c == 2 || c == 4; endfunction

    // one cycle: inputs already driven after a falling edge
    task automatic do_cycle(string req);
        int lo, hi, c, act_off;
        bit ovf, e_valid, e_sync, e_ready;
        #2;
        c  = int'(in_class);
        lo = mdl_off - int'(in_size);
        hi = mdl_off + int'(in_size);
        ovf = (f_push(c) && lo < -(1 << (OW-1))) || (f_pop(c) && hi > (1 << (OW-1)) - 1);
        e_valid = in_valid && !flush;
        e_sync  = e_valid && mdl_off != 0 && (in_sp_explicit || ovf);
        e_ready = !flush && out_ready && !e_sync;
        chk(req, "out_valid", int'(out_valid), int'(e_valid));
        chk(req, "in_ready", int'(in_ready), int'(e_ready));
        if (e_valid) begin
            act_off = $signed(out_offset);
            chk(req, "out_sync", int'(out_sync), int'(e_sync));
            if (e_sync) begin
                chk(req, "sync offset", act_off, mdl_off);
                chk(req, "sync class", int'(out_class), 0);
                chk(req, "sync tag", int'(out_tag), 0);
            end else begin
                chk(req, "offset", act_off, f_push(c) ? lo : mdl_off);
                chk(req, "class", int'(out_class), c);
                chk(req, "tag", int'(out_tag), int'(in_tag));
            end
        end
        last_accept = e_valid && out_ready && !e_sync;
        if (flush) mdl_off = 0;
        else if (e_valid && out_ready) begin
            if (e_sync)         mdl_off = 0;
            else if (f_push(c)) mdl_off = lo;
            else if (f_pop(c))  mdl_off = hi;
        end
        @(negedge clk);
    endtask

    task automatic op(int c, int sz, bit ex, int tg, string req);
        in_valid = 1; in_class = 3'(c); in_size = SW'(sz);
        in_sp_explicit = ex; in_tag = TW'(tg);
        for (int k = 0; k < 4; k++) begin
            do_cycle(req);
            if (last_accept) break;
        end
        in_valid = 0;
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit pend;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9: idle after reset
        do_cycle("R9");
        op(2, 0, 0, 1, "R9");              // zero-size pop shows offset 0
        // R1 two pushes: -4 then -8; R3 single uop
        op(1, 4, 0, 2, "R1");
        op(1, 4, 0, 3, "R3");
        // R10 non-stack op keeps offset
        op(0, 0, 0, 4, "R10");
        // R4 explicit: sync with -8, then op at 0
        op(0, 0, 1, 5, "R4");
        // R5 explicit at zero: no sync
        op(0, 0, 1, 6, "R5");
        // R2 pop/return
        op(2, 4, 0, 7, "R2");
        op(4, 4, 0, 8, "R2");
        op(3, 4, 0, 9, "R1");
        // R7 flush with a pending op
        flush = 1; in_valid = 1; in_class = 3'd1; in_size = 4'd4; do_cycle("R7");
        flush = 0; in_valid = 0;
        op(0, 0, 0, 10, "R7");
        // R6 downward overflow: 8 pushes reach -32, 9th syncs
        for (int i = 0; i < 9; i++) op(1, 4, 0, 11 + i, "R6");
        // R6 upward overflow with pops of 15
        for (int i = 0; i < 4; i++) op(2, 15, 0, 20 + i, "R6");
        // R8 stall then release
        out_ready = 0; in_valid = 1; in_class = 3'd1; in_size = 4'd3; in_tag = 6'd30;
        in_sp_explicit = 0;
        do_cycle("R8");
        do_cycle("R8");
        out_ready = 1;
        do_cycle("R8");
        in_valid = 0;

        // random phase
        pend = 0;
        for (int n = 0; n < 4000; n++) begin
            flush = ($urandom_range(0, 39) == 0);
            out_ready = ($urandom_range(0, 3) != 0);
            if (!pend && $urandom_range(0, 4) != 0) begin
                pend = 1;
                in_class = 3'($urandom_range(0, 4));
                in_size = ($urandom_range(0, 1) == 0) ? 4'd4 : SW'($urandom_range(1, 15));
                in_sp_explicit = ($urandom_range(0, 7) == 0);
                in_tag = TW'($urandom);
            end
            in_valid = pend;
            do_cycle("R3");
            if (last_accept) pend = 0;
        end
        flush = 0; in_valid = 0;
        do_cycle("R9");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule